// File: doc/BRIEF.md
# I2C Target with Selectable 7-bit / 10-bit Addressing

This block is the target side of an I2C bus. The system clock oversamples the SCL and SDA lines. The block finds START and STOP conditions on the bus and decodes the address that follows each START. It drives SDA low through an open-drain enable to acknowledge its own address, and it then exchanges any number of 8-bit data frames with local logic through a byte-wide interface.

A mode input selects the addressing scheme. In 7-bit mode the first byte after START holds the address and the read/write bit. In 10-bit mode the first byte holds a fixed header, pattern 11110, then address bits 9:8 and the read/write bit, and the second byte holds address bits 7:0. A 10-bit read uses a repeated START followed by the header with the read bit set. The target accepts it only if the full 10-bit address matched earlier in the same message.

Written bytes appear on a one-cycle strobe. For a read, the block raises a one-cycle request, and the local side puts the next byte on `rd_data` before the SCL falling edge that starts that byte.

Top module: `i2c_tgt_top`

## Requirements
- R1: After synchronous reset, `sda_oe`, `wr_valid` and `rd_req` are all 0.
- R2: After a STOP (SDA rising while SCL high), the target releases SDA and ignores bus traffic until the next START (SDA falling while SCL high): no acknowledge and no `wr_valid`.
- R3: In 7-bit mode (`ten_bit_mode`=0), the target acknowledges the first byte after START only when its bits 7:1 equal `own_addr[6:0]`; bit 0 is the read/write bit (1 = read). On a mismatch it never drives SDA and stays silent until the next START or STOP.
- R4: In 10-bit mode, a first byte of 11110, `own_addr[9:8]`, 0 is acknowledged. The second byte is acknowledged only when it equals `own_addr[7:0]`, and data bytes are accepted only after both bytes match. A header with other bits 2:1 is not acknowledged.
- R5: In 10-bit mode, a header with bit 0 = 1 is acknowledged and starts a read only after a full 10-bit match with the write bit earlier in the same message. Without that match it is not acknowledged.
- R6: In a write transfer, every 8-bit frame (MSB first on the bus) is acknowledged. It produces one `wr_valid` pulse with the byte on `wr_data`, and any number of frames may follow one address.
- R7: In a read transfer, `rd_req` pulses once per byte. `rd_data` is captured at the SCL falling edge that begins the byte and is shifted out MSB first. An acknowledge from the controller (SDA low) leads to another byte.
- R8: A NACK from the controller after a read byte makes the target release SDA. It then issues no further `rd_req` until a START.
- R9: A repeated START at any point, including inside a data byte or after a mismatched address, restarts address reception without a STOP. A partial byte is discarded.
- R10: The target changes `sda_oe` only while SCL is low.
- R11: `wr_valid` and `rd_req` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| own_addr | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_data | output | 8 | Received data byte, valid with `wr_valid` |
| rd_req | output | 1 | One-cycle request for the next byte to send |
| rd_data | input | 8 | Byte to send, captured at the start of a read byte |

## Verification
The bench aims at the points where the address decode has to hold state across a repeated START. A target that forgets the 10-bit match would NACK the read header. A target that keeps a stale match would accept a read header in a fresh message. A repeated START in the middle of a data byte checks that a design which only resets its bit counter on STOP would misalign the following address and miss its acknowledge. It also checks that such a design might emit the partial byte. After a controller NACK, the bench clocks another full byte and checks that the line reads all ones. A design that kept driving would corrupt that byte or issue an extra read request.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] HDR10_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR2,
    ST_WRITE,
    ST_ACK,
    ST_READ,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[STAGES-1:0], din[g]};
    end
    assign sync_o[g] = pipe[STAGES-1];
    assign prev_o[g] = pipe[STAGES];
  end
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit7_o,
  output logic              hdr_o,
  output logic              lo_o
);
  always_comb begin
    hit7_o = (byte_i[7:1] == addr_i[6:0]);
    hdr_o  = (byte_i[7:3] == HDR10_PREFIX) && (byte_i[2:1] == addr_i[9:8]);
    lo_o   = (byte_i == addr_i[7:0]);
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  input  logic              ten_mode,
  input  logic              hit7,
  input  logic              hdr_hit,
  input  logic              lo_hit,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] shreg_o,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgt_state_e        state_q, ack_next_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic              ten_ok_q, mack_q;

  logic start_det, stop_det, scl_rise, scl_fall;
  always_comb begin
    start_det = scl_s & scl_p & sda_p & ~sda_s;
    stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    scl_rise  = scl_s & ~scl_p;
    scl_fall  = ~scl_s & scl_p;
  end

  assign shreg_o = shreg_q;

  always_ff @(posedge clk) begin
    wr_valid <= 1'b0;
    rd_req   <= 1'b0;
    if (rst) begin
      state_q    <= ST_IDLE;
      ack_next_q <= ST_IDLE;
      shreg_q    <= '0;
      bitcnt_q   <= '0;
      ten_ok_q   <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe     <= 1'b0;
      wr_data    <= '0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      ten_ok_q <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_ADDR2, ST_WRITE: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (scl_fall && bitcnt_q == FULL) begin
            bitcnt_q <= '0;
            if (state_q == ST_WRITE) begin
              wr_valid   <= 1'b1;
              wr_data    <= shreg_q;
              sda_oe     <= 1'b1;
              ack_next_q <= ST_WRITE;
              state_q    <= ST_ACK;
            end else if (state_q == ST_ADDR2) begin
              if (lo_hit) begin
                ten_ok_q   <= 1'b1;
                sda_oe     <= 1'b1;
                ack_next_q <= ST_WRITE;
                state_q    <= ST_ACK;
              end else begin
                ten_ok_q <= 1'b0;
                state_q  <= ST_WAIT;
              end
            end else if (!ten_mode) begin
              if (hit7) begin
                sda_oe     <= 1'b1;
                ack_next_q <= shreg_q[0] ? ST_READ : ST_WRITE;
                state_q    <= ST_ACK;
              end else begin
                state_q <= ST_WAIT;
              end
            end else if (hdr_hit && !shreg_q[0]) begin
              sda_oe     <= 1'b1;
              ack_next_q <= ST_ADDR2;
              state_q    <= ST_ACK;
            end else if (hdr_hit && ten_ok_q) begin
              sda_oe     <= 1'b1;
              ack_next_q <= ST_READ;
              state_q    <= ST_ACK;
            end else begin
              ten_ok_q <= 1'b0;
              state_q  <= ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_rise && ack_next_q == ST_READ) begin
            rd_req <= 1'b1;
          end else if (scl_fall) begin
            if (ack_next_q == ST_READ) begin
              shreg_q  <= rd_data;
              sda_oe   <= ~rd_data[BYTE_W-1];
              bitcnt_q <= CNT_W'(1);
              state_q  <= ST_READ;
            end else begin
              sda_oe   <= 1'b0;
              bitcnt_q <= '0;
              state_q  <= ack_next_q;
            end
          end
        end
        ST_READ: begin
          if (scl_fall) begin
            if (bitcnt_q == FULL) begin
              sda_oe  <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              sda_oe   <= ~shreg_q[BYTE_W-2];
              shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
            rd_req <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              shreg_q  <= rd_data;
              sda_oe   <= ~rd_data[BYTE_W-1];
              bitcnt_q <= CNT_W'(1);
              state_q  <= ST_READ;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  assert_wait_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT || state_q == ST_IDLE) |-> !sda_oe);
  assert_drive_low_phase_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));
  assert_release_low_phase_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_oe) && !$past(start_det || stop_det)) |-> !$past(scl_s));
  assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  assert_wr_acked_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> sda_oe);
endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ten_bit_mode,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data
);
  logic [1:0]        line_s, line_p;
  logic [BYTE_W-1:0] shreg;
  logic              hit7, hdr_hit, lo_hit;

  i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    ({sda_i, scl_i}),
    .sync_o (line_s),
    .prev_o (line_p)
  );

  i2c_tgt_match u_match (
    .byte_i (shreg),
    .addr_i (own_addr),
    .hit7_o (hit7),
    .hdr_o  (hdr_hit),
    .lo_o   (lo_hit)
  );

  i2c_tgt_engine u_engine (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (line_s[0]),
    .scl_p    (line_p[0]),
    .sda_s    (line_s[1]),
    .sda_p    (line_p[1]),
    .ten_mode (ten_bit_mode),
    .hit7     (hit7),
    .hdr_hit  (hdr_hit),
    .lo_hit   (lo_hit),
    .rd_data  (rd_data),
    .shreg_o  (shreg),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .rd_req   (rd_req)
  );
endmodule

// File: tb/tb_i2c_tgt_top.sv
module tb_i2c_tgt_top;
  localparam int QT = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ten_bit_mode = 1'b0;
  logic [9:0] own_addr = 10'h05A;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, wr_valid, rd_req;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;
  logic       sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_tgt_top dut (
    .clk(clk), .rst(rst), .ten_bit_mode(ten_bit_mode), .own_addr(own_addr),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
  );

  int total = 0;
  int bad = 0;
  int rdreq_cnt = 0;
  int r10_viol = 0;
  int r11_viol = 0;
  logic [7:0] exp_wr[$];
  logic [7:0] rd_src[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor for written bytes
  initial forever begin
    @(negedge clk);
    if (!rst && wr_valid) begin
      if (exp_wr.size() == 0) chk(1'b0, "R6 unexpected write", {24'h0, wr_data}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_wr.pop_front();
        chk(wr_data == e, "R6 write data", {24'h0, wr_data}, {24'h0, e});
      end
    end
  end

  // Read data supplier
  initial forever begin
    @(negedge clk);
    if (!rst && rd_req) begin
      rdreq_cnt++;
      rd_data = (rd_src.size() != 0) ? rd_src.pop_front() : 8'hEE;
    end
  end

  // R10 / R11 protocol monitors
  initial begin
    logic p_oe, p_wr, p_rd;
    p_oe = 1'b0; p_wr = 1'b0; p_rd = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (sda_oe != p_oe && scl_m) r10_viol++;
        if (wr_valid && p_wr) r11_viol++;
        if (rd_req && p_rd) r11_viol++;
      end
      p_oe = sda_oe; p_wr = wr_valid; p_rd = rd_req;
    end
  end

  task automatic wq();
    repeat (QT) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_cycle(input bit b, output bit seen);
    sda_m = b; wq(); scl_m = 1'b1; wq(); seen = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(~give_ack, s);
    sda_m = 1'b1;
  endtask

  task automatic wr_frame(input logic [7:0] b, input string req);
    bit a;
    exp_wr.push_back(b);
    send_byte(b, a);
    chk(a, req, {31'h0, a}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] r;
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda_oe reset", {31'h0, sda_oe}, 32'h0);
    chk(wr_valid == 1'b0, "R1 wr_valid reset", {31'h0, wr_valid}, 32'h0);
    chk(rd_req == 1'b0, "R1 rd_req reset", {31'h0, rd_req}, 32'h0);
    wq();

    // R3 / R6: 7-bit write, several frames
    bus_start();
    send_byte(8'hB4, a);
    chk(a, "R3 7-bit address ack", {31'h0, a}, 32'h1);
    wr_frame(8'h3C, "R6 frame ack");
    wr_frame(8'hA5, "R6 frame ack");
    wr_frame(8'hFF, "R6 frame ack");
    wr_frame(8'h00, "R6 frame ack");
    bus_stop();
    wq();
    chk(exp_wr.size() == 0, "R6 all frames delivered", exp_wr.size(), 32'h0);

    // R3: wrong 7-bit address
    bus_start();
    send_byte(8'hB6, a);
    chk(!a, "R3 mismatch nack", {31'h0, a}, 32'h0);
    send_byte(8'h11, a);
    chk(!a, "R3 silent after mismatch", {31'h0, a}, 32'h0);
    bus_stop();

    // R7 / R8: 7-bit read
    rd_src.push_back(8'hC3); rd_src.push_back(8'h81); rd_src.push_back(8'h7E);
    base = rdreq_cnt;
    bus_start();
    send_byte(8'hB5, a);
    chk(a, "R3 read address ack", {31'h0, a}, 32'h1);
    recv_byte(1'b1, r); chk(r == 8'hC3, "R7 read byte 0", {24'h0, r}, 32'hC3);
    recv_byte(1'b1, r); chk(r == 8'h81, "R7 read byte 1", {24'h0, r}, 32'h81);
    recv_byte(1'b0, r); chk(r == 8'h7E, "R7 read byte 2", {24'h0, r}, 32'h7E);
    chk(rdreq_cnt - base == 3, "R7 request count", rdreq_cnt - base, 32'd3);
    recv_byte(1'b0, r);
    chk(r == 8'hFF, "R8 released after nack", {24'h0, r}, 32'hFF);
    chk(rdreq_cnt - base == 3, "R8 no request after nack", rdreq_cnt - base, 32'd3);
    bus_stop();

    // R9: repeated START inside a data byte
    bus_start();
    send_byte(8'hB4, a);
    begin
      bit s;
      bit_cycle(1'b1, s); bit_cycle(1'b0, s); bit_cycle(1'b1, s); bit_cycle(1'b0, s);
    end
    bus_start();
    send_byte(8'hB4, a);
    chk(a, "R9 address after mid-byte restart", {31'h0, a}, 32'h1);
    wr_frame(8'h42, "R9 frame after restart");
    // R9: repeated START after a mismatched address
    bus_start();
    send_byte(8'h20, a);
    chk(!a, "R9 mismatch nack", {31'h0, a}, 32'h0);
    bus_start();
    send_byte(8'hB4, a);
    chk(a, "R9 ack after restart from wait", {31'h0, a}, 32'h1);
    bus_stop();

    // R2: traffic after STOP without a START
    wq();
    scl_m = 1'b0; wq();
    send_byte(8'hB4, a);
    chk(!a, "R2 ignored after stop", {31'h0, a}, 32'h0);
    send_byte(8'h55, a);
    chk(!a, "R2 data ignored after stop", {31'h0, a}, 32'h0);
    bus_stop();

    // R4 / R5: 10-bit mode, address 0x2D6
    wq();
    ten_bit_mode = 1'b1; own_addr = 10'h2D6;
    wq();
    rd_src.push_back(8'h5E);
    base = rdreq_cnt;
    bus_start();
    send_byte(8'hF4, a);
    chk(a, "R4 header ack", {31'h0, a}, 32'h1);
    send_byte(8'hD6, a);
    chk(a, "R4 low byte ack", {31'h0, a}, 32'h1);
    wr_frame(8'h99, "R4 data after full match");
    bus_start();
    send_byte(8'hF5, a);
    chk(a, "R5 read header ack", {31'h0, a}, 32'h1);
    recv_byte(1'b0, r);
    chk(r == 8'h5E, "R5 10-bit read byte", {24'h0, r}, 32'h5E);
    chk(rdreq_cnt - base == 1, "R5 request count", rdreq_cnt - base, 32'd1);
    bus_stop();

    bus_start();
    send_byte(8'hF4, a);
    chk(a, "R4 header ack again", {31'h0, a}, 32'h1);
    send_byte(8'hD7, a);
    chk(!a, "R4 low byte mismatch nack", {31'h0, a}, 32'h0);
    send_byte(8'h12, a);
    chk(!a, "R4 no data after mismatch", {31'h0, a}, 32'h0);
    bus_stop();

    bus_start();
    send_byte(8'hF5, a);
    chk(!a, "R5 read header without match", {31'h0, a}, 32'h0);
    bus_stop();

    bus_start();
    send_byte(8'hF0, a);
    chk(!a, "R4 header high bits mismatch", {31'h0, a}, 32'h0);
    bus_stop();

    wq();
    chk(exp_wr.size() == 0, "R6 scoreboard drained", exp_wr.size(), 32'h0);
    chk(r10_viol == 0, "R10 sda_oe changed with SCL high", r10_viol, 32'h0);
    chk(r11_viol == 0, "R11 strobe longer than one cycle", r11_viol, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule